// File: doc/BRIEF.md
# Two-Word Letter Sequencer for a Seven-Segment Digit

This block drives one common-anode seven-segment digit so that it spells one of two three-letter words, one letter per clock cycle, repeating forever. A single select input picks the word: with the select low the digit cycles through A, b, C; with it high the digit cycles through C, b, S. A two-bit state register holds the letter on show, and the segment lines are decoded from that register alone, so the displayed glyph only ever changes at a rising clock edge.

Both words draw on one shared set of four letters. The letter b is common to both words, and a letter that belongs only to the other word (A in the second word, S in the first) has a defined exit, so flipping the select at any time moves the machine onto the chosen word within one clock.

Top module: `char_word_display`

## Requirements
- R1: A synchronous active-high reset, sampled at a rising clock edge, puts the machine in the A letter, and the digit shows A after that edge.
- R2: The output pins `seg_n[6:0]` carry segments a..g on bits 6..0, active low. Active high, A is 1110111, b is 0011111, C is 1001110 and S is 1011011; the pins show the bitwise inverse. No other pattern ever appears out of reset.
- R3: With the select at 0 the digit steps A, then b, then C, then back to A, one letter per rising edge.
- R4: With the select at 1 the digit steps C, then b, then S, then back to C, one letter per rising edge.
- R5: From A with the select at 1, the next letter is C.
- R6: From S with the select at 0, the next letter is A.
- R7: A change of the select between edges does not alter the letter already shown; it only steers the transition at the next rising edge.
- R8: From b, the next letter is C when the select is 0 and S when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_sel | input | 1 | Word select: 0 spells A-b-C, 1 spells C-b-S |
| seg_n | output | 7 | Segment lines a..g on bits 6..0, active low |

## Verification
The bound checker watches every cycle that the digit shows only one of the four legal glyphs, that reset lands on A, and that each letter's successor matches the select sampled at that edge, including the exits from A under select 1 and from S under select 0. What the checker cannot show is that a select change in mid-cycle leaves the glyph alone until the next edge, and that a long run under each select keeps repeating the right word; the bench's scenarios cover those, along with switching words from every letter, including the shared b.

// File: rtl/char_word_display.sv
module char_word_display (
  input  logic       clk,
  input  logic       rst,
  input  logic       word_sel,
  output logic [6:0] seg_n
);

  typedef enum logic [1:0] {
    LTR_A = 2'b00,
    LTR_B = 2'b01,
    LTR_C = 2'b10,
    LTR_S = 2'b11
  } letter_t;

  letter_t cur, nxt;

  always_ff @(posedge clk) begin
    if (rst) cur <= LTR_A;
    else     cur <= nxt;
  end

  always_comb begin
    unique case (cur)
      LTR_A:   nxt = word_sel ? LTR_C : LTR_B;
      LTR_B:   nxt = word_sel ? LTR_S : LTR_C;
      LTR_C:   nxt = word_sel ? LTR_B : LTR_A;
      default: nxt = word_sel ? LTR_C : LTR_A;
    endcase
  end

  logic [6:0] glyph;

  always_comb begin
    unique case (cur)
      LTR_A:   glyph = 7'b1110111;
      LTR_B:   glyph = 7'b0011111;
      LTR_C:   glyph = 7'b1001110;
      default: glyph = 7'b1011011;
    endcase
  end

  assign seg_n = ~glyph;

endmodule

// File: rtl/char_word_display_chk.sv
module char_word_display_chk (
  input logic       clk,
  input logic       rst,
  input logic       word_sel,
  input logic [6:0] seg_n
);

  localparam logic [6:0] PIN_A = 7'b0001000;
  localparam logic [6:0] PIN_B = 7'b1100000;
  localparam logic [6:0] PIN_C = 7'b0110001;
  localparam logic [6:0] PIN_S = 7'b0100100;

  assert_reset_to_a_R1: assert property (@(posedge clk)
    rst |=> seg_n == PIN_A);

  assert_legal_glyph_R2: assert property (@(posedge clk) disable iff (rst)
    (seg_n == PIN_A || seg_n == PIN_B || seg_n == PIN_C || seg_n == PIN_S));

  assert_first_a_to_b_R3: assert property (@(posedge clk) disable iff (rst)
    (!word_sel && seg_n == PIN_A) |=> seg_n == PIN_B);

  assert_first_c_to_a_R3: assert property (@(posedge clk) disable iff (rst)
    (!word_sel && seg_n == PIN_C) |=> seg_n == PIN_A);

  assert_second_c_to_b_R4: assert property (@(posedge clk) disable iff (rst)
    (word_sel && seg_n == PIN_C) |=> seg_n == PIN_B);

  assert_second_s_to_c_R4: assert property (@(posedge clk) disable iff (rst)
    (word_sel && seg_n == PIN_S) |=> seg_n == PIN_C);

  assert_a_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (word_sel && seg_n == PIN_A) |=> seg_n == PIN_C);

  assert_s_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (!word_sel && seg_n == PIN_S) |=> seg_n == PIN_A);

  assert_b_fork_R8: assert property (@(posedge clk) disable iff (rst)
    (seg_n == PIN_B) |=> (seg_n == (word_sel ? PIN_B : PIN_B) ? 1'b0 : 1'b1) &&
                         (seg_n == ($past(word_sel) ? PIN_S : PIN_C)));

endmodule

bind char_word_display char_word_display_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .word_sel (word_sel),
  .seg_n    (seg_n)
);

// File: tb/char_word_display_bench.sv
module char_word_display_bench;

  localparam logic [6:0] PIN_A = 7'b0001000;
  localparam logic [6:0] PIN_B = 7'b1100000;
  localparam logic [6:0] PIN_C = 7'b0110001;
  localparam logic [6:0] PIN_S = 7'b0100100;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_sel = 1'b0;
  logic [6:0] seg_n;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  item_t sb[$];

  always #10 clk = ~clk;

  char_word_display u_char_word_display (
    .clk      (clk),
    .rst      (rst),
    .word_sel (word_sel),
    .seg_n    (seg_n)
  );

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (seg_n !== it.exp) begin
        n_fail++;
        $display("FAIL %s: seg_n=%b expected %b", it.tag, seg_n, it.exp);
      end
    end
  end

  task automatic step(input logic r, input logic m, input logic [6:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    word_sel = m;
    @(posedge clk);
    #2;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step_flip(input logic m, input logic [6:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b0;
    word_sel = m;
    @(posedge clk);
    #2;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
    #3;
    word_sel = ~m;
  endtask

  initial begin
    step(1'b1, 1'b0, PIN_A, "R1 reset shows A");
    step(1'b1, 1'b1, PIN_A, "R1 reset holds A under select 1");
    // R3: first word, two full rounds
    step(1'b0, 1'b0, PIN_B, "R3 A->b");
    step(1'b0, 1'b0, PIN_C, "R3 b->C");
    step(1'b0, 1'b0, PIN_A, "R3 C->A");
    step(1'b0, 1'b0, PIN_B, "R3 A->b round 2");
    step(1'b0, 1'b0, PIN_C, "R3 b->C round 2");
    step(1'b0, 1'b0, PIN_A, "R3 C->A round 2");
    // R5: exit from A into second word
    step(1'b0, 1'b1, PIN_C, "R5 A with select 1 -> C");
    // R4: second word, two rounds
    step(1'b0, 1'b1, PIN_B, "R4 C->b");
    step(1'b0, 1'b1, PIN_S, "R4 b->S");
    step(1'b0, 1'b1, PIN_C, "R4 S->C");
    step(1'b0, 1'b1, PIN_B, "R4 C->b round 2");
    step(1'b0, 1'b1, PIN_S, "R4 b->S round 2");
    // R6: exit from S into first word
    step(1'b0, 1'b0, PIN_A, "R6 S with select 0 -> A");
    // R8: fork at b
    step(1'b0, 1'b0, PIN_B, "R8 setup A->b");
    step(1'b0, 1'b1, PIN_S, "R8 b with select 1 -> S");
    step(1'b0, 1'b1, PIN_C, "R8 setup S->C");
    step(1'b0, 1'b1, PIN_B, "R8 setup C->b");
    step(1'b0, 1'b0, PIN_C, "R8 b with select 0 -> C");
    // R2: C under select 0 returns A; each glyph pattern already compared
    step(1'b0, 1'b0, PIN_A, "R2 glyph A after C");
    // R7: mid-cycle select flips do not disturb the glyph
    step_flip(1'b0, PIN_B, "R7 glyph b held across select flip");
    step(1'b0, 1'b1, PIN_S, "R7 new select used at next edge");
    step_flip(1'b1, PIN_C, "R7 glyph C held across select flip");
    step(1'b0, 1'b0, PIN_A, "R7 new select 0 used at next edge");
    // R1: reset from mid-word
    step(1'b0, 1'b1, PIN_C, "R1 setup A->C");
    step(1'b0, 1'b1, PIN_B, "R1 setup C->b");
    step(1'b1, 1'b1, PIN_A, "R1 reset from b shows A");
    step(1'b0, 1'b0, PIN_B, "R3 after reset A->b");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule